// File: doc/BRIEF.md
# Seven-Segment Shift-Chain Driver

This block refreshes a row of seven-segment digits that hang off a chain of cascaded serial-in, parallel-out registers. Every register in the chain shares one shift clock and one storage clock. The serial output of each register feeds the serial input of the next. A single strobe starts a transfer. The block captures the digit values, converts each one to an active-low segment pattern, and sends the patterns most significant bit first on one data line. It then applies one storage edge, so that every digit changes at the same moment.

The controller drives the storage (latch) line low before the first bit goes out. It keeps the line low while the bytes for all stages are clocked through the chain. After the last bit it waits a fixed settling time, then raises the line once. The shift clock idles high. Its period is an even number of system clocks, and data changes only while the shift clock is low. The digit at index 0 is sent last, so it ends up in the stage nearest the controller. The busy flag covers the whole transfer, and a new strobe is only accepted after busy falls.

Top module: `seg_chain_driver`

## Requirements
- R1: After reset, and whenever no transfer is in progress, shift_clk_o and latch_o are high, busy_o is low and ser_data_o is high; a reset during a transfer returns the block to this idle state at once.
- R2: Each 4-bit digit value is sent as an active-low segment byte: 0→0x42, 1→0xF3, 2→0x86, 3→0xA2, 4→0x33, 5→0x2A, 6→0x0A, 7→0xF2, 8→0x02, 9→0x22, and any value 10 to 15 → 0xFF (all segments dark).
- R3: Bytes go out starting with digit index count−1 and ending with digit index 0. Digit i sits in bits [4i+3:4i] of digits_i. Each byte is sent MSB first. ser_data_o changes only on falling shift-clock edges and is stable at every rising edge.
- R4: A transfer of N digits produces exactly 8·N rising shift-clock edges. The shift clock is low for HALF_DIV system clocks and then high for HALF_DIV system clocks, giving a period of 2·HALF_DIV.
- R5: latch_o falls in the cycle after a start is accepted. The first shift-clock falling edge comes HALF_DIV cycles later. latch_o stays low at every rising shift-clock edge of the transfer.
- R6: latch_o rises exactly once per transfer, HALF_DIV + SETTLE_CYC system clocks after the final rising shift-clock edge.
- R7: busy_o rises in the cycle after an accepted start and falls in the same cycle in which latch_o rises.
- R8: A start strobe that arrives while busy_o is high is ignored. The transfer in progress sends its original bytes, and no second transfer follows.
- R9: A start with count_i = 0 is ignored. A count above N_DIG is treated as N_DIG.
- R10: Digit values are captured when the start is accepted. Changes on digits_i during a transfer do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| count_i | input | $clog2(N_DIG+1) | Number of digits to send |
| digits_i | input | 4·N_DIG | Digit values, digit i in bits [4i+3:4i] |
| ser_data_o | output | 1 | Serial data to the first register of the chain |
| shift_clk_o | output | 1 | Shift clock, idles high, data taken on rising edge |
| latch_o | output | 1 | Storage clock, low during shifting, rising edge updates digits |
| busy_o | output | 1 | High while a transfer is in progress |

## Verification
Complete transfers are run with digit patterns chosen to tell faults apart. Ascending and descending digit sets show whether bytes are sent in the wrong order or bits within a byte are reversed. An all-eight pattern and repeated values catch a wrong segment entry. A single-digit transfer shows whether the byte count is off by one. Codes 10 to 15 show whether the blank mapping is missing. Directed runs cover the following: a second strobe during a transfer, digit inputs changing mid-transfer, a zero count, a count above the chain length, and reset in the middle of shifting. Each run checks the edge spacing, the single latch edge and its delay after the last bit.

// File: rtl/seg_chain_pkg.sv
package seg_chain_pkg;

  localparam int DIG_W = 4;
  localparam int SEG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_SETTLE
  } chain_state_t;

  // Active-low segment patterns; unused codes blank the digit.
  function automatic logic [SEG_W-1:0] seg_code(input logic [DIG_W-1:0] v);
    case (v)
      4'd0:    seg_code = 8'h42;
      4'd1:    seg_code = 8'hF3;
      4'd2:    seg_code = 8'h86;
      4'd3:    seg_code = 8'hA2;
      4'd4:    seg_code = 8'h33;
      4'd5:    seg_code = 8'h2A;
      4'd6:    seg_code = 8'h0A;
      4'd7:    seg_code = 8'hF2;
      4'd8:    seg_code = 8'h02;
      4'd9:    seg_code = 8'h22;
      default: seg_code = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/seg_code_map.sv
module seg_code_map
  import seg_chain_pkg::*;
#(
  parameter int N_DIG = 4
) (
  input  logic [N_DIG*DIG_W-1:0] digits_i,
  output logic [N_DIG*SEG_W-1:0] codes_o
);

  // R2: one lookup per digit position
  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    assign codes_o[g*SEG_W +: SEG_W] = seg_code(digits_i[g*DIG_W +: DIG_W]);
  end

endmodule

// File: rtl/seg_chain_shifter.sv
module seg_chain_shifter
  import seg_chain_pkg::*;
#(
  parameter int N_DIG      = 4,
  parameter int HALF_DIV   = 2,
  parameter int SETTLE_CYC = 6,
  localparam int CNT_W     = $clog2(N_DIG + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [N_DIG*SEG_W-1:0] codes_i,
  output logic                   ser_data_o,
  output logic                   shift_clk_o,
  output logic                   latch_o,
  output logic                   busy_o
);

  localparam int TOT_W   = N_DIG * SEG_W;
  localparam int BIT_W   = $clog2(TOT_W + 1);
  localparam int TMR_MAX = (HALF_DIV > SETTLE_CYC) ? HALF_DIV : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  chain_state_t       state_q;
  logic [TOT_W-1:0]   shreg_q;
  logic [BIT_W-1:0]   bits_left_q;
  logic [TMR_W-1:0]   tmr_q;

  logic [CNT_W-1:0]   eff_cnt;
  logic [BIT_W-1:0]   load_bits;
  logic [TOT_W-1:0]   load_vec;
  logic               tmr_done;

  // R9: clamp oversize counts to the chain length
  assign eff_cnt   = (count_i > CNT_W'(N_DIG)) ? CNT_W'(N_DIG) : count_i;
  assign load_bits = BIT_W'(eff_cnt) << 3;
  // Left-align so digit count-1 leaves first (R3)
  assign load_vec  = codes_i << (BIT_W'(TOT_W) - load_bits);
  assign tmr_done  = (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      bits_left_q <= '0;
      tmr_q       <= '0;
      ser_data_o  <= 1'b1;
      shift_clk_o <= 1'b1;
      latch_o     <= 1'b1;
      busy_o      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i && (eff_cnt != '0)) begin
            shreg_q     <= load_vec;   // R10: capture once
            bits_left_q <= load_bits;
            latch_o     <= 1'b0;       // R5
            busy_o      <= 1'b1;       // R7
            tmr_q       <= TMR_W'(HALF_DIV - 1);
            state_q     <= ST_LEAD;
          end
        end
        ST_LEAD, ST_HIGH: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (bits_left_q != '0) begin
            shift_clk_o <= 1'b0;       // data moves on the falling edge
            ser_data_o  <= shreg_q[TOT_W-1];
            shreg_q     <= {shreg_q[TOT_W-2:0], 1'b0};
            bits_left_q <= bits_left_q - 1'b1;
            tmr_q       <= TMR_W'(HALF_DIV - 1);
            state_q     <= ST_LOW;
          end else begin
            ser_data_o  <= 1'b1;
            tmr_q       <= TMR_W'(SETTLE_CYC - 1);
            state_q     <= ST_SETTLE;
          end
        end
        ST_LOW: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            shift_clk_o <= 1'b1;       // chain samples here
            tmr_q       <= TMR_W'(HALF_DIV - 1);
            state_q     <= ST_HIGH;
          end
        end
        ST_SETTLE: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            latch_o <= 1'b1;           // R6: single storage edge
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_chain_driver.sv
module seg_chain_driver
  import seg_chain_pkg::*;
#(
  parameter int N_DIG      = 4,
  parameter int HALF_DIV   = 2,
  parameter int SETTLE_CYC = 6,
  localparam int CNT_W     = $clog2(N_DIG + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [N_DIG*DIG_W-1:0] digits_i,
  output logic                   ser_data_o,
  output logic                   shift_clk_o,
  output logic                   latch_o,
  output logic                   busy_o
);

  logic [N_DIG*SEG_W-1:0] codes;

  seg_code_map #(
    .N_DIG (N_DIG)
  ) i_map (
    .digits_i (digits_i),
    .codes_o  (codes)
  );

  seg_chain_shifter #(
    .N_DIG      (N_DIG),
    .HALF_DIV   (HALF_DIV),
    .SETTLE_CYC (SETTLE_CYC)
  ) i_shift (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .count_i     (count_i),
    .codes_i     (codes),
    .ser_data_o  (ser_data_o),
    .shift_clk_o (shift_clk_o),
    .latch_o     (latch_o),
    .busy_o      (busy_o)
  );

endmodule

// File: rtl/seg_chain_checker.sv
module seg_chain_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             ser_data_o,
  input logic             shift_clk_o,
  input logic             latch_o,
  input logic             busy_o
);

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (shift_clk_o && latch_o));

  p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_clk_o) |-> $stable(ser_data_o));

  p_latch_low_shift_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_clk_o) |-> (!latch_o && busy_o));

  p_latch_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_o) |-> ($past(busy_o) && !busy_o));

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (count_i != '0)) |=> (busy_o && !latch_o));

endmodule

bind seg_chain_driver seg_chain_checker #(
  .CNT_W (CNT_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .count_i     (count_i),
  .ser_data_o  (ser_data_o),
  .shift_clk_o (shift_clk_o),
  .latch_o     (latch_o),
  .busy_o      (busy_o)
);

// File: tb/test_seg_chain_driver.sv
module test_seg_chain_driver;

  localparam int N_DIG  = 4;
  localparam int HALF   = 2;
  localparam int SETTLE = 6;
  localparam int CNT_W  = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [15:0]      dig = '0;
  logic             sdata, sclk, latch, busy;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  seg_chain_driver #(
    .N_DIG      (N_DIG),
    .HALF_DIV   (HALF),
    .SETTLE_CYC (SETTLE)
  ) i_seg_chain_driver (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .count_i     (cnt),
    .digits_i    (dig),
    .ser_data_o  (sdata),
    .shift_clk_o (sclk),
    .latch_o     (latch),
    .busy_o      (busy)
  );

  // Stimulus/expectation table: {count, digits, effective count}
  localparam logic [22:0] VECS [0:5] = '{
    {3'd4, 16'h3210, 4'd4},
    {3'd4, 16'h6789, 4'd4},
    {3'd3, 16'h0543, 4'd3},
    {3'd1, 16'h0008, 4'd1},
    {3'd4, 16'hFEDC, 4'd4},
    {3'd2, 16'h0B0A, 4'd2}
  };

  function automatic logic [7:0] ref_seg(input logic [3:0] v);
    logic [7:0] t [0:9];
    t = '{8'h42, 8'hF3, 8'h86, 8'hA2, 8'h33, 8'h2A, 8'h0A, 8'hF2, 8'h02, 8'h22};
    return (v <= 4'd9) ? t[v] : 8'hFF;
  endfunction

  function automatic logic [31:0] ref_stream(input int eff, input logic [15:0] d);
    logic [31:0] e = '0;
    for (int i = 0; i < eff; i++) e |= 32'(ref_seg(d[4*i +: 4])) << (8*i);
    return e;
  endfunction

  // Cycle counter and line monitor
  int cyc = 0;
  always @(posedge clk) cyc++;

  bit          p_sclk = 1'b1, p_latch = 1'b1, first_pend = 1'b0;
  int          nbits = 0, nlrise = 0, terr = 0, hibad = 0;
  int          last_rise = 0, last_fall = 0, latch_fall = 0, lrise_cyc = 0;
  logic [31:0] cap = '0;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 1'b1;
      p_latch = 1'b1;
      first_pend = 1'b0;
    end else begin
      if (!p_latch && latch) begin nlrise++; lrise_cyc = cyc; end
      if (p_latch && !latch) begin latch_fall = cyc; first_pend = 1'b1; end
      if (p_sclk && !sclk) begin
        if (first_pend) begin
          if (cyc - latch_fall != HALF) terr++;
          first_pend = 1'b0;
        end else if (cyc - last_rise != HALF) terr++;
        last_fall = cyc;
      end
      if (!p_sclk && sclk) begin
        if (cyc - last_fall != HALF) terr++;
        nbits++;
        cap = {cap[30:0], sdata};
        if (latch) hibad++;
        last_rise = cyc;
      end
      p_sclk = sclk;
      p_latch = latch;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int s_bits, s_lr, s_terr, s_hib;

  task automatic snap();
    s_bits = nbits; s_lr = nlrise; s_terr = terr; s_hib = hibad;
  endtask

  task automatic begin_xfer(input logic [CNT_W-1:0] c, input logic [15:0] d);
    snap();
    @(negedge clk); start = 1'b1; cnt = c; dig = d;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && latch == 1'b0, "R7 busy/latch after start", {busy, latch}, 2'b10);
  endtask

  task automatic finish_xfer(input int eff, input logic [15:0] d);
    int w = 0;
    logic [31:0] mask;
    while (busy && w < 5000) begin @(negedge clk); w++; end
    chk(w < 5000, "R7 transfer ends", w, 0);
    repeat (4) @(negedge clk);
    mask = (eff >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*eff)) - 1);
    chk(nbits - s_bits == 8*eff, "R4 shift edge count", nbits - s_bits, 8*eff);
    chk((cap & mask) == ref_stream(eff, d), "R2/R3 byte stream", cap & mask, ref_stream(eff, d));
    chk(nlrise - s_lr == 1, "R6 single latch edge", nlrise - s_lr, 1);
    chk(lrise_cyc - last_rise == HALF + SETTLE, "R6 settle delay", lrise_cyc - last_rise, HALF + SETTLE);
    chk(terr - s_terr == 0, "R4/R5 edge spacing", terr - s_terr, 0);
    chk(hibad - s_hib == 0, "R5 latch low while shifting", hibad - s_hib, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk({sclk, latch, busy, sdata} == 4'b1101, "R1 reset idle", {sclk, latch, busy, sdata}, 4'b1101);

    // Table walk (R2, R3, R4, R5, R6, R7)
    for (int v = 0; v < 6; v++) begin
      begin_xfer(VECS[v][22:20], VECS[v][19:4]);
      finish_xfer(int'(VECS[v][3:0]), VECS[v][19:4]);
    end

    // R8: second strobe mid-transfer ignored
    begin_xfer(3'd4, 16'h1357);
    repeat (20) @(negedge clk);
    start = 1'b1; cnt = 3'd2; dig = 16'h2468;
    @(negedge clk); start = 1'b0; dig = 16'h1357;
    finish_xfer(4, 16'h1357);
    chk(busy == 1'b0 && nbits - s_bits == 32, "R8 no follow-on transfer", nbits - s_bits, 32);

    // R10: digit inputs change during the transfer
    begin_xfer(3'd4, 16'h4321);
    repeat (10) @(negedge clk);
    dig = 16'h9999;
    finish_xfer(4, 16'h4321);

    // R9: zero count ignored
    snap();
    @(negedge clk); start = 1'b1; cnt = 3'd0; dig = 16'h1111;
    @(negedge clk); start = 1'b0;
    begin
      int busy_seen = 0;
      for (int i = 0; i < 12; i++) begin
        if (busy || !latch || !sclk) busy_seen++;
        @(negedge clk);
      end
      chk(busy_seen == 0 && nbits == s_bits, "R9 zero count ignored", busy_seen, 0);
    end

    // R9: oversize count clamps to N_DIG
    begin_xfer(3'd7, 16'h5678);
    finish_xfer(4, 16'h5678);

    // R1: reset in the middle of shifting
    begin_xfer(3'd4, 16'h2222);
    repeat (15) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sclk, latch, busy, sdata} == 4'b1101, "R1 reset mid-transfer", {sclk, latch, busy, sdata}, 4'b1101);
    snap();
    repeat (40) @(negedge clk);
    chk(nbits == s_bits && busy == 1'b0, "R1 stays idle after reset", nbits - s_bits, 0);

    // Transfer works after the aborted one
    begin_xfer(3'd2, 16'h0090);
    finish_xfer(2, 16'h0090);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule